// File: doc/BRIEF.md
# Magic Packet Frame Detector

This block watches the bytes of received frames and reports when a wake-up frame arrives while wake mode is on. A wake-up frame carries, somewhere in its payload, a run of six all-ones bytes followed at once by sixteen back-to-back copies of the station's 48-bit physical address. The detector also checks the frame's destination address. In strict mode the destination must equal the station address. If either of two accept bits is set, any destination is taken: unicast, multicast or broadcast.

Bytes arrive one per cycle when `rx_valid` is high. `rx_sof` marks the first byte of a frame and `rx_eof` marks the last. The first six bytes of a frame are the destination address. Every byte after them is payload and is searched. When the byte that completes the sixteenth copy is accepted, a registered single-cycle pulse appears on `match_pulse` in the following cycle. This pulse feeds a status bit elsewhere. Frame check sequence validation, receive framing and power control are handled outside this block.

Top module: `wake_frame_detector`

## Requirements
- R1: While `wake_mode` is low, `match_pulse` never rises, whatever the frames contain.
- R2: With both `accept_any_a` and `accept_any_b` low, a frame matches only if its bytes 0..5 equal the station address. Byte 0 of the frame is compared with `station_addr[47:40]` and byte 5 with `station_addr[7:0]`.
- R3: With either accept bit high, the destination bytes are not compared, so unicast, multicast and broadcast destinations all qualify.
- R4: The accept bits do not relax the payload rule. A frame with fewer than sixteen complete copies gives no pulse even when an accept bit is set.
- R5: The payload must contain six consecutive 0xFF bytes, then sixteen copies of the station address in the R2 byte order. `match_pulse` is high for exactly one cycle, the cycle after the byte that completes the sixteenth copy is accepted. Five 0xFF bytes do not count as a sync run.
- R6: The sync run may begin at any payload position (frame byte 6 onward), including after unrelated bytes and after shorter 0xFF runs.
- R7: A byte that breaks the address copies sends the search back to sync hunting. 0xFF bytes at and after the break count toward a new sync run, so a sync run that overlaps a broken sequence is still found.
- R8: At most one pulse is issued per frame, even when the payload holds two full wake sequences.
- R9: `rx_sof` restarts all detection state. Bytes with `rx_valid` high that come after an `rx_eof` byte and before the next `rx_sof` are ignored.
- R10: After synchronous reset, `match_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_mode | input | 1 | Wake detection enable |
| accept_any_a | input | 1 | First destination-relax bit |
| accept_any_b | input | 1 | Second destination-relax bit |
| station_addr | input | 48 | Station physical address; bits 47:40 are sent first |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| match_pulse | output | 1 | One-cycle wake frame detected |

## Verification
The bench builds the block with its default parameters: a six-byte address, sixteen copies and a six-byte sync run. This makes the full 96-byte copy sequence, the saturation of the 0xFF run counter and the boundary between header and payload all reachable in short frames. The test frames cover a 0xFF run that is one byte too short, a copy sequence broken by a sync run that overlaps it, a payload holding two wake sequences, and bytes that arrive after the end of a frame.

// File: rtl/wfd_pkg.sv
package wfd_pkg;
  typedef enum logic {SCAN_SYNC = 1'b0, SCAN_COPY = 1'b1} scan_state_e;
endpackage

// File: rtl/wfd_dest_check.sv
module wfd_dest_check #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         byte_en,
  input  logic                         sof,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic                         relax,
  output logic                         payload_now,
  output logic                         dest_ok
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic [IDX_W-1:0]  idx_q, cur_idx;
  logic              ok_q, cur_ok, ok_d;
  logic [BYTE_W-1:0] exp_byte;

  always_comb begin
    cur_idx  = sof ? '0 : idx_q;
    cur_ok   = sof ? 1'b1 : ok_q;
    exp_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cur_idx == IDX_W'(i))
        exp_byte = station_addr[BYTE_W*(ADDR_BYTES-1-i) +: BYTE_W];
    end
    payload_now = (cur_idx == IDX_W'(ADDR_BYTES));
    ok_d        = cur_ok & (relax | (data == exp_byte));
    dest_ok     = cur_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ok_q  <= 1'b1;
    end else if (byte_en && !payload_now) begin
      idx_q <= cur_idx + IDX_W'(1);
      ok_q  <= ok_d;
    end
  end
endmodule

// File: rtl/wfd_payload_scan.sv
module wfd_payload_scan
  import wfd_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int COPIES     = 16,
  parameter int SYNC_LEN   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         byte_en,
  input  logic                         sof,
  input  logic                         payload_now,
  input  logic [BYTE_W-1:0]            data,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  output logic                         copy_done
);
  localparam int AW   = ADDR_BYTES * BYTE_W;
  localparam int BI_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CC_W = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam int TL_W = $clog2(SYNC_LEN + 1);

  scan_state_e       state_q, state_d;
  logic [TL_W-1:0]   tail_q, tail_d;
  logic [BI_W-1:0]   bidx_q, bidx_d;
  logic [CC_W-1:0]   ccnt_q, ccnt_d;
  logic [BYTE_W-1:0] exp_byte, first_byte;
  logic              is_ones, restart_hit, done_raw;

  always_comb begin
    is_ones    = (data == {BYTE_W{1'b1}});
    first_byte = station_addr[AW-1 -: BYTE_W];
    exp_byte   = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (bidx_q == BI_W'(i))
        exp_byte = station_addr[BYTE_W*(ADDR_BYTES-1-i) +: BYTE_W];
    end
    if (!is_ones)                          tail_d = '0;
    else if (tail_q == TL_W'(SYNC_LEN))    tail_d = tail_q;
    else                                   tail_d = tail_q + TL_W'(1);
    restart_hit = (tail_q == TL_W'(SYNC_LEN)) && (data == first_byte);

    state_d  = state_q;
    bidx_d   = bidx_q;
    ccnt_d   = ccnt_q;
    done_raw = 1'b0;
    case (state_q)
      SCAN_SYNC: begin
        if (restart_hit) begin
          state_d = SCAN_COPY;
          bidx_d  = BI_W'(1);
          ccnt_d  = '0;
        end
      end
      default: begin
        if (data == exp_byte) begin
          if (bidx_q == BI_W'(ADDR_BYTES-1)) begin
            bidx_d = '0;
            if (ccnt_q == CC_W'(COPIES-1)) begin
              done_raw = 1'b1;
              state_d  = SCAN_SYNC;
              ccnt_d   = '0;
            end else begin
              ccnt_d = ccnt_q + CC_W'(1);
            end
          end else begin
            bidx_d = bidx_q + BI_W'(1);
          end
        end else if (restart_hit) begin
          bidx_d = BI_W'(1);
          ccnt_d = '0;
        end else begin
          state_d = SCAN_SYNC;
          bidx_d  = '0;
          ccnt_d  = '0;
        end
      end
    endcase
    copy_done = byte_en & payload_now & done_raw;
  end

  always_ff @(posedge clk) begin
    if (rst || (byte_en && sof)) begin
      state_q <= SCAN_SYNC;
      tail_q  <= '0;
      bidx_q  <= '0;
      ccnt_q  <= '0;
    end else if (byte_en && payload_now) begin
      state_q <= state_d;
      tail_q  <= tail_d;
      bidx_q  <= bidx_d;
      ccnt_q  <= ccnt_d;
    end
  end
endmodule

// File: rtl/wake_frame_detector.sv
module wake_frame_detector #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int COPIES     = 16,
  parameter int SYNC_LEN   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wake_mode,
  input  logic                         accept_any_a,
  input  logic                         accept_any_b,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  input  logic                         rx_valid,
  input  logic                         rx_sof,
  input  logic                         rx_eof,
  input  logic [BYTE_W-1:0]            rx_data,
  output logic                         match_pulse
);
  logic in_frame_q, byte_en, payload_now, dest_ok, copy_done, fired_q, fire;

  assign byte_en = rx_valid & (rx_sof | in_frame_q);

  wfd_dest_check #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_dest (
    .clk(clk), .rst(rst), .byte_en(byte_en), .sof(rx_sof), .data(rx_data),
    .station_addr(station_addr), .relax(accept_any_a | accept_any_b),
    .payload_now(payload_now), .dest_ok(dest_ok)
  );

  wfd_payload_scan #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W),
                     .COPIES(COPIES), .SYNC_LEN(SYNC_LEN)) u_scan (
    .clk(clk), .rst(rst), .byte_en(byte_en), .sof(rx_sof),
    .payload_now(payload_now), .data(rx_data),
    .station_addr(station_addr), .copy_done(copy_done)
  );

  assign fire = copy_done & dest_ok & wake_mode & ~fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q  <= 1'b0;
      fired_q     <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      match_pulse <= fire;
      if (rx_valid) begin
        if (rx_sof)         in_frame_q <= ~rx_eof;
        else if (rx_eof)    in_frame_q <= 1'b0;
      end
      if (byte_en && rx_sof) fired_q <= 1'b0;
      else if (fire)         fired_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wake_frame_detector_checker.sv
module wake_frame_detector_checker (
  input logic clk,
  input logic rst,
  input logic wake_mode,
  input logic rx_valid,
  input logic rx_sof,
  input logic match_pulse
);
  logic [1:0] pulses_in_frame;

  always_ff @(posedge clk) begin
    if (rst)                    pulses_in_frame <= '0;
    else if (rx_valid && rx_sof) pulses_in_frame <= '0;
    else if (match_pulse && pulses_in_frame != 2'd3)
      pulses_in_frame <= pulses_in_frame + 2'd1;
  end

  // R1
  a_r1_mode_gates: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(wake_mode));
  // R5
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> !match_pulse);
  // R6 (the start-of-frame byte is a destination byte, never the last copy byte)
  a_r6_not_on_sof: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> !$past(rx_valid && rx_sof));
  // R8
  a_r8_once_per_frame: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> (pulses_in_frame == 2'd0));
endmodule

bind wake_frame_detector wake_frame_detector_checker u_chk (
  .clk(clk), .rst(rst), .wake_mode(wake_mode), .rx_valid(rx_valid),
  .rx_sof(rx_sof), .match_pulse(match_pulse)
);

// File: tb/wake_frame_detector_bench.sv
module wake_frame_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA = 48'h02_1A_3C_4D_5E_6F;

  logic clk = 1'b0;
  logic rst, wake_mode, acc_a, acc_b, rx_valid, rx_sof, rx_eof, match_pulse;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  logic [7:0] fb [0:511];
  int fl, mark, pulse_cnt, pulse_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_frame_detector u_wake_frame_detector (
    .clk(clk), .rst(rst), .wake_mode(wake_mode), .accept_any_a(acc_a),
    .accept_any_b(acc_b), .station_addr(STA), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .match_pulse(match_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b); fb[fl] = b; fl++; endtask
  task automatic put_ff(input int n); for (int i = 0; i < n; i++) put(8'hFF); endtask
  task automatic put_addr(input logic [47:0] a);
    for (int i = 0; i < 6; i++) put(a[8*(5-i) +: 8]);
  endtask
  task automatic put_copies(input int n);
    for (int i = 0; i < n; i++) put_addr(STA);
    mark = fl - 1;
  endtask
  task automatic put_header(input logic [47:0] dst);
    fl = 0; put_addr(dst); put_addr(48'hA0_B1_C2_D3_E4_F5); put(8'h08); put(8'h42);
  endtask

  // drive fb[0..fl-1]; with_frame=0 drives bytes with neither sof nor eof
  task automatic drive(input bit with_frame);
    pulse_cnt = 0; pulse_idx = -1;
    for (int i = 0; i <= fl; i++) begin
      @(negedge clk);
      if (match_pulse) begin pulse_cnt++; pulse_idx = i - 1; end
      if (i < fl) begin
        rx_valid = 1'b1; rx_data = fb[i];
        rx_sof = with_frame && (i == 0);
        rx_eof = with_frame && (i == fl - 1);
      end else begin
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      end
    end
    @(negedge clk);
    if (match_pulse) begin pulse_cnt++; pulse_idx = fl - 1; end
  endtask

  task automatic expect_frame(input string req, input int exp_cnt, input int exp_idx);
    drive(1'b1);
    check(pulse_cnt == exp_cnt, req, pulse_cnt, exp_cnt);
    if (exp_cnt > 0) check(pulse_idx == exp_idx, {req, " position"}, pulse_idx, exp_idx);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(match_pulse == 1'b0, "R10 reset", match_pulse, 0);
  endtask

  task automatic t_basic();
    put_header(STA); put_ff(6); put_copies(16); put(8'h11);
    expect_frame("R5 R2 basic wake", 1, mark);
  endtask

  task automatic t_mode_off();
    wake_mode = 1'b0;
    put_header(STA); put_ff(6); put_copies(16);
    expect_frame("R1 mode off", 0, 0);
    wake_mode = 1'b1;
  endtask

  task automatic t_dest();
    put_header(48'h02_1A_3C_4D_5E_70); put_ff(6); put_copies(16);
    expect_frame("R2 strict dest mismatch", 0, 0);
    acc_a = 1'b1;
    expect_frame("R3 accept a unicast other", 1, mark);
    acc_a = 1'b0; acc_b = 1'b1;
    put_header(48'hFF_FF_FF_FF_FF_FF); put_ff(6); put_copies(16);
    expect_frame("R3 accept b broadcast", 1, mark);
    put_header(48'h01_00_5E_00_00_01); put_ff(6); put_copies(16);
    expect_frame("R3 accept b multicast", 1, mark);
    acc_b = 1'b0;
  endtask

  task automatic t_relax_payload();
    acc_a = 1'b1;
    put_header(STA); put_ff(6); put_copies(15); put_ff(2); put(8'h00);
    expect_frame("R4 relaxed but 15 copies", 0, 0);
    acc_a = 1'b0;
  endtask

  task automatic t_short_sync();
    put_header(STA); put(8'h00); put_ff(5); put_copies(16);
    expect_frame("R5 five sync bytes", 0, 0);
  endtask

  task automatic t_late_sync();
    put_header(STA); put(8'h55); put_ff(3); put(8'h12); put_ff(4); put(8'h9A);
    put_ff(6); put_copies(16);
    expect_frame("R6 sync after junk", 1, mark);
  endtask

  task automatic t_overlap();
    put_header(STA); put_ff(6); put(8'h02); put(8'h1A);
    put_ff(6); put_copies(16);
    expect_frame("R7 overlap after break", 1, mark);
    put_header(STA); put_ff(6); put_copies(5); put(8'h02); put(8'h00);
    put_copies(11);
    expect_frame("R7 break without sync", 0, 0);
  endtask

  task automatic t_twice();
    int first;
    put_header(STA); put_ff(6); put_copies(16); first = mark;
    put_ff(6); put_copies(16);
    expect_frame("R8 two sequences", 1, first);
  endtask

  task automatic t_framing();
    put_header(STA); put_ff(6); put_copies(10);
    drive(1'b1);
    fl = 0; put_copies(6);
    drive(1'b0);
    check(pulse_cnt == 0, "R9 bytes after eof ignored", pulse_cnt, 0);
    put_header(STA); put_ff(6); put_copies(16);
    expect_frame("R9 new frame after ignored bytes", 1, mark);
    // frame restarted by sof: old sequence must not carry over
    put_header(STA); put_ff(6); put_copies(10);
    fl = fl - 1;
    drive(1'b1);
    fl = 0; put_addr(STA); put_addr(48'h0); put(8'h08); put(8'h00); put_copies(6);
    expect_frame("R9 sof restarts scan", 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wake_mode = 1'b1; acc_a = 1'b0; acc_b = 1'b0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_mode_off();
    t_dest();
    t_relax_payload();
    t_short_sync();
    t_late_sync();
    t_overlap();
    t_twice();
    t_framing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule